// File: doc/BRIEF.md
# Banked chip-select address decoder

This block routes CPU accesses onto an external parallel bus that has eight chip selects. Each bank owns one programmable window register, set up through a plain 32-bit register port. A window is described by a base address and a compare mask. Both are held at 128 KiB granularity, so every window is a naturally aligned power-of-two region. For each valid CPU address, the decoder tests every participating window. It asserts the active-low chip select of the winning bank and drives the offset of the address within that bank. When no window matches, it raises a one-cycle miss flag.

Two hardware quirks are modelled on purpose.

- **Banks 0 and 1 ignore their enable bit.** An all-zero register in one of these banks therefore captures the whole bus space. Writing all ones parks such a bank instead, because its window then lies above the decoded space.
- **The boot-swap strap exchanges chip selects 0 and 1.** The strap is sampled while reset is held. When it was high, the bank 0 register resets with its enable bit clear.

Software first programs the windows and parks any unused low bank. After that it issues accesses.

Top module: `bank_sel_decoder`

## Requirements
- R1: The window register of bank n sits at register address 0x100 + 0x10*n for n = 0..7. It reads back exactly the last value written to it. A write to any other register address changes no window, and reading any other address returns zero.
- R2: Register layout: bit 0 is the enable, bits 31:17 are the base, and bit 16 is unused. Bits 15:1 form the compare mask, where mask bit i+1 selects address bit 17+i. A bank hits when its base and address bits 31:17 agree on every bit the mask selects.
- R3: A bank numbered 2 to 7 takes part in decoding only while its enable bit is 1.
- R4: Banks 0 and 1 take part whatever their enable bit. An all-zero register captures every decoded address, and an all-ones register matches none of them.
- R5: Only addresses whose bits 31:28 equal 4 are decoded. When the parameter ALT_SPACE_EN is 1, bits 31:28 equal to 0 are also decoded. Any other valid address is a miss.
- R6: When several banks hit, the lowest-numbered bank wins. At most one chip select is ever low.
- R7: For a hit, bank_offset equals the CPU address minus {base, 17 zero bits} of the winning bank.
- R8: A valid address that hits no bank drives decode_miss high for one cycle, with all chip selects high and bank_offset zero.
- R9: Outputs are registered. A request presented at one rising edge appears after that edge. A cycle with cpu_valid low yields all chip selects high, decode_miss low and bank_offset zero.
- R10: Reset is synchronous and active high. It clears every window register, except that bank 0 resets to 1 when the strap is low and to 0 when the strap is high.
- R11: With the strap captured high, a hit on bank 0 drives cs_n[1] low and a hit on bank 1 drives cs_n[0] low.
- R12: A register write affects decoding from the next cycle on. An access at the same edge as the write is decoded with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_swap_strap | input | 1 | Strap captured while rst is high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| cpu_valid | input | 1 | CPU address valid |
| cpu_addr | input | 32 | CPU address |
| cs_n | output | 8 | Active-low chip selects |
| bank_offset | output | 32 | Offset within selected bank |
| decode_miss | output | 1 | One-cycle flag for an unmatched access |

## Verification
A corrupted window register or priority chain shows at the ports on the cycle after the next affected access, in one of three ways: the wrong chip select goes low, the offset is wrong, or a miss appears where a hit was due. A lost boot-swap bit appears as chip selects 0 and 1 trading places on the first low-bank hit after reset. A stuck enable shows as a missing or extra hit on a bank in the range 2 to 7. Register upsets also show straight away on reg_rdata, so the bench reads back the window registers after the writes and checks that the wrong addresses were ignored.

// File: rtl/bank_sel_pkg.sv
`timescale 1ns/1ps
package bank_sel_pkg;
    localparam int NUM_BANKS    = 8;
    localparam int BANK_IDX_W   = $clog2(NUM_BANKS);
    localparam int ADDR_W       = 32;
    localparam int REG_ADDR_W   = 12;
    localparam int GRAN_LSB     = 17;
    localparam int FIELD_W      = ADDR_W - GRAN_LSB;
    localparam int STRIDE_LSB   = 4;
    localparam int STICKY_BANKS = 2;
    localparam logic [REG_ADDR_W-1:0] WIN_REG_BASE = 12'h100;
    localparam logic [3:0] SPACE_MAIN = 4'h4;
    localparam logic [3:0] SPACE_ALT  = 4'h0;

    typedef struct packed {
        logic [FIELD_W-1:0] base;
        logic               spare;
        logic [FIELD_W-1:0] cmp_mask;
        logic               enable;
    } win_reg_t;

    typedef struct packed {
        logic                  hit;
        logic [BANK_IDX_W-1:0] idx;
    } slot_t;

    function automatic slot_t reg_slot(logic [REG_ADDR_W-1:0] a);
        slot_t s;
        logic [REG_ADDR_W-1:0] rel;
        rel   = a - WIN_REG_BASE;
        s.idx = rel[STRIDE_LSB +: BANK_IDX_W];
        s.hit = (a >= WIN_REG_BASE)
             && (rel[STRIDE_LSB-1:0] == '0)
             && (rel[REG_ADDR_W-1:STRIDE_LSB+BANK_IDX_W] == '0);
        return s;
    endfunction

    function automatic logic win_match(win_reg_t w, logic [ADDR_W-1:0] a);
        return (((a[ADDR_W-1:GRAN_LSB] ^ w.base) & w.cmp_mask) == '0);
    endfunction

    function automatic logic [ADDR_W-1:0] win_base_addr(win_reg_t w);
        return {w.base, {GRAN_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/bank_window_regs.sv
`timescale 1ns/1ps
module bank_window_regs
    import bank_sel_pkg::*;
#(
    parameter int NB = NUM_BANKS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  boot_strap,
    input  logic                  we,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0]     wdata,
    output logic [ADDR_W-1:0]     rdata,
    output win_reg_t [NB-1:0]     win_q,
    output logic                  swap_q
);
    slot_t slot;
    assign slot = reg_slot(addr);

    always_ff @(posedge clk) begin
        if (rst) swap_q <= boot_strap;
    end

    for (genvar n = 0; n < NB; n++) begin : g_bank
        win_reg_t rst_val;
        assign rst_val = (n == 0) ? win_reg_t'({{(ADDR_W-1){1'b0}}, ~boot_strap}) : '0;

        always_ff @(posedge clk) begin
            if (rst)
                win_q[n] <= rst_val;
            else if (we && slot.hit && (slot.idx == BANK_IDX_W'(n)))
                win_q[n] <= win_reg_t'(wdata);
        end

        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
            (we && slot.hit && (slot.idx == BANK_IDX_W'(n))) |=> (win_q[n] == $past(wdata))); // R12
    end

    always_comb begin
        rdata = slot.hit ? ADDR_W'(win_q[slot.idx]) : '0;
    end

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> $stable(swap_q)); // R10
endmodule

// File: rtl/bank_match.sv
`timescale 1ns/1ps
module bank_match
    import bank_sel_pkg::*;
#(
    parameter int NB = NUM_BANKS
) (
    input  win_reg_t [NB-1:0]     win_q,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  in_space,
    output logic [NB-1:0]         hit_vec,
    output logic [BANK_IDX_W-1:0] sel_idx,
    output logic                  any_hit
);
    for (genvar n = 0; n < NB; n++) begin : g_cmp
        logic live;
        if (n < STICKY_BANKS) begin : g_sticky
            assign live = 1'b1;
        end else begin : g_gated
            assign live = win_q[n].enable;
        end
        assign hit_vec[n] = in_space && live && win_match(win_q[n], addr);
    end

    always_comb begin
        sel_idx = '0;
        any_hit = 1'b0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_idx = BANK_IDX_W'(i);
                any_hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cs_output_stage.sv
`timescale 1ns/1ps
module cs_output_stage
    import bank_sel_pkg::*;
#(
    parameter int NB = NUM_BANKS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  swap,
    input  logic                  req_valid,
    input  logic                  any_hit,
    input  logic [BANK_IDX_W-1:0] sel_idx,
    input  logic [ADDR_W-1:0]     offset_in,
    output logic [NB-1:0]         cs_n,
    output logic [ADDR_W-1:0]     offset,
    output logic                  miss
);
    logic [NB-1:0] onehot;
    logic [NB-1:0] routed;

    always_comb begin
        onehot = any_hit ? (NB'(1) << sel_idx) : '0;
        routed = onehot;
        if (swap) begin
            routed[0] = onehot[1];
            routed[1] = onehot[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            cs_n   <= '1;
            offset <= '0;
            miss   <= 1'b0;
        end else begin
            cs_n   <= ~routed;
            offset <= any_hit ? offset_in : '0;
            miss   <= !any_hit;
        end
    end

    AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1); // R6
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        miss |-> ((&cs_n) && (offset == '0))); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ((&cs_n) && !miss)); // R9
    AST_SWAP_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && any_hit && swap && (sel_idx == '0)) |=> !cs_n[1]); // R11
endmodule

// File: rtl/bank_sel_decoder.sv
`timescale 1ns/1ps
module bank_sel_decoder
    import bank_sel_pkg::*;
#(
    parameter bit ALT_SPACE_EN = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        boot_swap_strap,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cpu_valid,
    input  logic [31:0] cpu_addr,
    output logic [7:0]  cs_n,
    output logic [31:0] bank_offset,
    output logic        decode_miss
);
    localparam int NB = NUM_BANKS;

    win_reg_t [NB-1:0]     win_q;
    logic                  swap_q;
    logic                  in_space;
    logic [NB-1:0]         hit_vec;
    logic [BANK_IDX_W-1:0] sel_idx;
    logic                  any_hit;
    logic [ADDR_W-1:0]     rel_offset;

    bank_window_regs #(.NB(NB)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .boot_strap (boot_swap_strap),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .win_q      (win_q),
        .swap_q     (swap_q)
    );

    assign in_space = (cpu_addr[ADDR_W-1 -: 4] == SPACE_MAIN)
                   || (ALT_SPACE_EN && (cpu_addr[ADDR_W-1 -: 4] == SPACE_ALT));

    bank_match #(.NB(NB)) u_match (
        .win_q    (win_q),
        .addr     (cpu_addr),
        .in_space (in_space),
        .hit_vec  (hit_vec),
        .sel_idx  (sel_idx),
        .any_hit  (any_hit)
    );

    assign rel_offset = cpu_addr - win_base_addr(win_q[sel_idx]);

    cs_output_stage #(.NB(NB)) u_out (
        .clk       (clk),
        .rst       (rst),
        .swap      (swap_q),
        .req_valid (cpu_valid),
        .any_hit   (any_hit),
        .sel_idx   (sel_idx),
        .offset_in (rel_offset),
        .cs_n      (cs_n),
        .offset    (bank_offset),
        .miss      (decode_miss)
    );

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> ((hit_vec & ((NB'(1) << sel_idx) - NB'(1))) == '0)); // R6
    AST_OUT_OF_SPACE: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && !in_space) |=> decode_miss); // R5
endmodule

// File: tb/bank_sel_decoder_test.sv
`timescale 1ns/1ps
module bank_sel_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_valid = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [7:0]  cs_n;
    logic [31:0] bank_offset;
    logic        decode_miss;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [7:0]  cs_n;
        logic        miss;
        logic [31:0] off;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [31:0] sh[8];
    bit          swap_m;

    always #2.5 clk = ~clk;

    bank_sel_decoder uut (
        .clk             (clk),
        .rst             (rst),
        .boot_swap_strap (strap),
        .reg_we          (reg_we),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .cpu_valid       (cpu_valid),
        .cpu_addr        (cpu_addr),
        .cs_n            (cs_n),
        .bank_offset     (bank_offset),
        .decode_miss     (decode_miss)
    );

    function automatic exp_t predict(bit v, logic [31:0] a, string tag);
        exp_t e;
        bit   found;
        int   w;
        int   phys;
        e.cs_n = 8'hFF; e.miss = 1'b0; e.off = '0; e.tag = tag;
        found = 0; w = 0;
        if (!v) return e;
        if (a[31:28] == 4'h4) begin
            for (int b = 0; b < 8; b++) begin
                if (!found && ((b < 2) || sh[b][0]) &&
                    (((a[31:17] ^ sh[b][31:17]) & sh[b][15:1]) == 15'h0)) begin
                    found = 1; w = b;
                end
            end
        end
        if (found) begin
            phys = (swap_m && w < 2) ? 1 - w : w;
            e.cs_n = ~(8'h01 << phys);
            e.off  = a - {sh[w][31:17], 17'h0};
        end else begin
            e.miss = 1'b1;
        end
        return e;
    endfunction

    task automatic step(bit v, logic [31:0] a, bit we, logic [11:0] wa,
                        logic [31:0] wd, string tag);
        @(negedge clk);
        cpu_valid = v; cpu_addr = a;
        reg_we = we; reg_addr = wa; reg_wdata = wd;
        q.push_back(predict(v, a, tag));
        if (we && wa >= 12'h100 && wa <= 12'h170 && wa[3:0] == 4'h0)
            sh[(wa - 12'h100) >> 4] = wd;
    endtask

    task automatic acc(logic [31:0] a, string tag);
        step(1'b1, a, 1'b0, 12'h0, 32'h0, tag);
    endtask

    task automatic wr(logic [11:0] wa, logic [31:0] wd, string tag);
        step(1'b0, 32'h0, 1'b1, wa, wd, tag);
    endtask

    task automatic rd(logic [11:0] wa, logic [31:0] exp, string tag);
        @(negedge clk);
        cpu_valid = 1'b0; reg_we = 1'b0; reg_addr = wa;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s: reg[%h] read %h expected %h", tag, wa, reg_rdata, exp);
        end
    endtask

    task automatic do_reset(bit s);
        wait (q.size() == 0);
        @(negedge clk);
        rst = 1'b1; strap = s; cpu_valid = 1'b0; reg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        swap_m = s;
        for (int b = 0; b < 8; b++) sh[b] = 32'h0;
        sh[0] = s ? 32'h0 : 32'h1;
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (cs_n !== e.cs_n || decode_miss !== e.miss || bank_offset !== e.off) begin
                fails++;
                $display("FAIL %s: cs_n=%h miss=%b off=%h expected cs_n=%h miss=%b off=%h",
                         e.tag, cs_n, decode_miss, bank_offset, e.cs_n, e.miss, e.off);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete (all requirements)");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // strap low
        do_reset(1'b0);
        rd(12'h100, 32'h1, "R10");
        rd(12'h110, 32'h0, "R10");
        rd(12'h170, 32'h0, "R10");
        acc(32'h4000_1234, "R4");
        step(1'b0, 32'h4000_1234, 1'b0, 12'h0, 32'h0, "R9");
        wr(12'h100, 32'hFFFF_FFFF, "R4");
        wr(12'h110, 32'hFFFF_FFFF, "R4");
        wr(12'h120, 32'h4200_FE01, "R2");
        wr(12'h150, 32'h4600_FF01, "R2");
        wr(12'h140, 32'h4A00_FE01, "R2");
        rd(12'h120, 32'h4200_FE01, "R1");
        rd(12'h100, 32'hFFFF_FFFF, "R1");
        acc(32'h43F0_0000, "R7");
        acc(32'h4620_0000, "R7");
        acc(32'h4BFF_FFFF, "R2");
        acc(32'h4C00_0000, "R8");
        step(1'b0, 32'h0, 1'b0, 12'h0, 32'h0, "R8");
        acc(32'h5000_0000, "R5");
        acc(32'h0000_1000, "R5");
        wr(12'h104, 32'h1234_5678, "R1");
        wr(12'h180, 32'h1234_5678, "R1");
        rd(12'h104, 32'h0, "R1");
        rd(12'h150, 32'h4600_FF01, "R1");
        rd(12'h170, 32'h0, "R1");
        wr(12'h150, 32'h4600_FF00, "R3");
        acc(32'h4620_0000, "R3");
        wr(12'h130, 32'h4000_F001, "R6");
        acc(32'h43F0_0000, "R6");
        acc(32'h4400_0000, "R6");
        step(1'b1, 32'h4620_0000, 1'b1, 12'h110, 32'h0, "R12");
        acc(32'h4620_0000, "R12");
        acc(32'h43F0_0000, "R4");
        step(1'b0, 32'h0, 1'b0, 12'h0, 32'h0, "R9");

        // strap high
        do_reset(1'b1);
        rd(12'h100, 32'h0, "R10");
        acc(32'h4000_0000, "R11");
        wr(12'h100, 32'hFFFF_FFFF, "R11");
        acc(32'h4100_0000, "R11");
        wr(12'h120, 32'h4200_FE01, "R4");
        acc(32'h43F0_0000, "R4");
        step(1'b0, 32'h0, 1'b0, 12'h0, 32'h0, "R9");
        wait (q.size() == 0);
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule